// File: doc/BRIEF.md
# Half-Bridge Gate Command Conditioner with Turn-On Delay

This block sits in front of the two gate-driver inputs of a half-bridge power stage. It takes one or two PWM commands and produces a registered high-side and low-side gate command. In the single-input modes it makes the complementary command for the second switch. The polarity is chosen so that the switch doing the active work follows PWM-high. In buck mode that is the upper switch, and in boost mode it is the lower switch. In dual-input mode the two commands are routed straight through, the first to the upper gate and the second to the lower gate.

Each gate has its own turn-on delay. The delay is a 4-bit count of clock cycles that holds back only the rising edge of that gate, so that one switch has fully turned off before the other starts to turn on. Falling edges are never delayed. Two bypass settings are available. The first keeps the polarity logic and drops the delays. The second routes the raw inputs to the gates. Mode, path and delay values are static configuration.

At a 100 MHz clock, a delay of 1 cycle corresponds to 10 ns. The input commands are expected to respect a minimum high time of 50 ns on the upper command and a minimum low time of 200 ns, so that the bootstrap supply can recharge. When shoot-through protection is in force, the block also records in a sticky flag any cycle in which both gate outputs are high.

Top module: `hb_gate_front`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `gate_hi`, `gate_lo` and `overlap_err` are all low.
- R2: With `in_mode`=0 (buck) and `path_sel`=0, the upper gate request equals `pwm_a` and the lower gate request equals the inverse of `pwm_a`. `pwm_b` is ignored.
- R3: With `in_mode`=1 (boost) and `path_sel`=0, the lower gate request equals `pwm_a` and the upper gate request equals the inverse of `pwm_a`. `pwm_b` is ignored.
- R4: With `in_mode`=2 or 3 (dual), the upper request equals `pwm_a` and the lower request equals `pwm_b`. Both gates may be high together.
- R5: A gate output rises `dt+1` clock cycles after its request rises, provided the request stays high throughout. `dt` is `dt_hi` for the upper gate and `dt_lo` for the lower gate, and the value 0 adds no delay beyond the one output register.
- R6: A gate output falls exactly one clock cycle after its request falls, whatever the delay setting.
- R7: If a request falls before its delay count completes, the gate stays low and the count starts again from zero on the next rising request.
- R8: With `path_sel`=1 (delay bypass), the polarity routing of R2 to R4 applies and both delays are treated as 0.
- R9: With `path_sel`=2 or 3 (full bypass), `gate_hi` follows `pwm_a` and `gate_lo` follows `pwm_b`, each one cycle later, in any `in_mode`.
- R10: The protected setting is `path_sel`=0 with `in_mode` 0 or 1. Once it has held for a cycle, the two gates are never high together. `overlap_err` goes high in the cycle after a cycle in which both gates are high while the setting is protected, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a | input | 1 | First PWM command |
| pwm_b | input | 1 | Second PWM command (dual mode and full bypass only) |
| in_mode | input | 2 | 0 buck, 1 boost, 2/3 dual |
| path_sel | input | 2 | 0 conditioned, 1 delay bypass, 2/3 full bypass |
| dt_hi | input | DT_W | Turn-on delay of the upper gate, in cycles |
| dt_lo | input | DT_W | Turn-on delay of the lower gate, in cycles |
| gate_hi | output | 1 | Registered upper gate command |
| gate_lo | output | 1 | Registered lower gate command |
| overlap_err | output | 1 | Sticky flag for both gates high while protected |

## Verification
In a single-input mode, one edge of `pwm_a` turns one gate off and starts the turn-on count of the other gate at the same clock edge. The bench toggles `pwm_a` with random hold times around the programmed delays, including holds shorter than the delay. At each edge it judges that the falling gate drops after one cycle while the rising gate waits `dt+1` cycles. A second case places the overlap detector and a mode change in the same cycle. The bench holds both gates high in dual mode and then switches to a protected buck setting. It expects `overlap_err` to rise at the next edge and to remain set until reset.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        IN_BUCK     = 2'd0,
        IN_BOOST    = 2'd1,
        IN_DUAL     = 2'd2,
        IN_DUAL_ALT = 2'd3
    } in_mode_e;

    typedef enum logic [1:0] {
        PATH_COND    = 2'd0,
        PATH_NODT    = 2'd1,
        PATH_RAW     = 2'd2,
        PATH_RAW_ALT = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        DLY_IDLE  = 2'd0,
        DLY_COUNT = 2'd1,
        DLY_ON    = 2'd2
    } dly_state_e;

    localparam int GATES = 2;
    localparam int G_HI  = 0;
    localparam int G_LO  = 1;

endpackage

// File: rtl/hb_route.sv
module hb_route
    import hb_pkg::*;
(
    input  logic     pwm_a,
    input  logic     pwm_b,
    input  in_mode_e mode,
    input  path_e    path,
    output logic     req_hi,
    output logic     req_lo,
    output logic     use_dt,
    output logic     protect
);

    logic pol_hi;
    logic pol_lo;
    logic single;

    // polarity and input selection
    always_comb begin
        pol_hi = pwm_a;
        pol_lo = pwm_b;
        single = 1'b0;
        unique case (mode)
            IN_BUCK: begin
                pol_hi = pwm_a;
                pol_lo = ~pwm_a;
                single = 1'b1;
            end
            IN_BOOST: begin
                pol_hi = ~pwm_a;
                pol_lo = pwm_a;
                single = 1'b1;
            end
            IN_DUAL, IN_DUAL_ALT: begin
                pol_hi = pwm_a;
                pol_lo = pwm_b;
                single = 1'b0;
            end
        endcase
    end

    // path selection
    always_comb begin
        req_hi  = pol_hi;
        req_lo  = pol_lo;
        use_dt  = 1'b0;
        protect = 1'b0;
        unique case (path)
            PATH_COND: begin
                use_dt  = 1'b1;
                protect = single;
            end
            PATH_NODT: begin
                use_dt = 1'b0;
            end
            PATH_RAW, PATH_RAW_ALT: begin
                req_hi = pwm_a;
                req_lo = pwm_b;
            end
        endcase
    end

endmodule

// File: rtl/hb_turnon_delay.sv
module hb_turnon_delay
    import hb_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [DT_W-1:0] dt,
    output logic            gate
);

    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    dly_state_e      state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DLY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DLY_IDLE: begin
                cnt_d = '0;
                if (req) begin
                    if (dt == '0) begin
                        state_d = DLY_ON;
                    end else begin
                        state_d = DLY_COUNT;
                        cnt_d   = CNT_ONE;
                    end
                end
            end
            DLY_COUNT: begin
                if (!req) begin
                    state_d = DLY_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q >= dt) begin
                    state_d = DLY_ON;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            DLY_ON: begin
                cnt_d = '0;
                if (!req) begin
                    state_d = DLY_IDLE;
                end
            end
            default: begin
                state_d = DLY_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // output decode from the state register
    always_comb begin
        gate = (state_q == DLY_ON);
    end

endmodule

// File: rtl/hb_gate_front.sv
module hb_gate_front
    import hb_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_a,
    input  logic            pwm_b,
    input  logic [1:0]      in_mode,
    input  logic [1:0]      path_sel,
    input  logic [DT_W-1:0] dt_hi,
    input  logic [DT_W-1:0] dt_lo,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            overlap_err
);

    logic             req_hi;
    logic             req_lo;
    logic             use_dt;
    logic             protect;
    logic [GATES-1:0] req_v;
    logic [GATES-1:0] gate_v;
    logic [DT_W-1:0]  dt_v [GATES];
    logic             err_q;

    hb_route route_i (
        .pwm_a   (pwm_a),
        .pwm_b   (pwm_b),
        .mode    (in_mode_e'(in_mode)),
        .path    (path_e'(path_sel)),
        .req_hi  (req_hi),
        .req_lo  (req_lo),
        .use_dt  (use_dt),
        .protect (protect)
    );

    always_comb begin
        req_v[G_HI] = req_hi;
        req_v[G_LO] = req_lo;
        dt_v[G_HI]  = use_dt ? dt_hi : '0;
        dt_v[G_LO]  = use_dt ? dt_lo : '0;
    end

    for (genvar g = 0; g < GATES; g++) begin : g_gate
        hb_turnon_delay #(.DT_W(DT_W)) dly_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_v[g]),
            .dt    (dt_v[g]),
            .gate  (gate_v[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (protect && gate_v[G_HI] && gate_v[G_LO]) begin
            err_q <= 1'b1;
        end
    end

    assign gate_hi     = gate_v[G_HI];
    assign gate_lo     = gate_v[G_LO];
    assign overlap_err = err_q;

endmodule

// File: rtl/hb_gate_front_chk.sv
module hb_gate_front_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_a,
    input logic pwm_b,
    input logic raw,
    input logic protect,
    input logic req_hi,
    input logic req_lo,
    input logic gate_hi,
    input logic gate_lo,
    input logic overlap_err
);

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (protect && $past(protect)) |-> !(gate_hi && gate_lo));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err);

    // R6
    hi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_hi) |=> !gate_hi);

    // R6
    lo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_lo) |=> !gate_lo);

    // R5
    hi_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(req_hi));

    // R5
    lo_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> $past(req_lo));

    // R9
    raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && $past(raw) && $past(rst_n)) |->
            (gate_hi == $past(pwm_a) && gate_lo == $past(pwm_b)));

endmodule

bind hb_gate_front hb_gate_front_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_a       (pwm_a),
    .pwm_b       (pwm_b),
    .raw         (path_sel[1]),
    .protect     (protect),
    .req_hi      (req_hi),
    .req_lo      (req_lo),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .overlap_err (overlap_err)
);

// File: tb/hb_gate_front_tb_top.sv
module hb_gate_front_tb_top;

    localparam int DT_W = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            pwm_a, pwm_b;
    logic [1:0]      in_mode, path_sel;
    logic [DT_W-1:0] dt_hi, dt_lo;
    logic            gate_hi, gate_lo, overlap_err;

    int total = 0;
    int bad   = 0;

    int   run_hi, run_lo;
    logic exp_hi, exp_lo, exp_err;
    string force_tag = "";

    always #5 clk = ~clk;

    hb_gate_front #(.DT_W(DT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .in_mode(in_mode), .path_sel(path_sel), .dt_hi(dt_hi), .dt_lo(dt_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .overlap_err(overlap_err)
    );

    task automatic chk(input string tag, input string what, input logic got, input logic want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s %s got=%0b exp=%0b t=%0t", tag, what, got, want, $time);
        end
    endtask

    function automatic string cfg_tag();
        if (path_sel[1])       return "R9";
        if (path_sel == 2'd1)  return "R8";
        if (in_mode == 2'd0)   return "R2";
        if (in_mode == 2'd1)   return "R3";
        return "R4";
    endfunction

    function automatic logic want_req(input logic hi, input logic a, input logic b);
        if (path_sel[1]) return hi ? a : b;
        if (in_mode == 2'd0) return hi ? a : ~a;
        if (in_mode == 2'd1) return hi ? ~a : a;
        return hi ? a : b;
    endfunction

    function automatic int eff_dt(input logic [DT_W-1:0] v);
        return (path_sel == 2'd0) ? int'(v) : 0;
    endfunction

    function automatic logic protected_cfg();
        return (path_sel == 2'd0) && (in_mode[1] == 1'b0);
    endfunction

    function automatic string edge_tag(input logic prev, input logic nxt, input int d);
        if (force_tag != "") return force_tag;
        if (!prev && nxt && d > 0) return "R5";
        if (prev && !nxt) return "R6";
        return cfg_tag();
    endfunction

    // one clock: drive at a quiet point, predict, check at the next falling edge
    task automatic cycle(input logic a, input logic b);
        logic rh, rl, nh, nl, ne;
        string th, tl;
        pwm_a = a;
        pwm_b = b;
        rh = want_req(1'b1, a, b);
        rl = want_req(1'b0, a, b);
        run_hi = rh ? ((run_hi < 40) ? run_hi + 1 : 40) : 0;
        run_lo = rl ? ((run_lo < 40) ? run_lo + 1 : 40) : 0;
        nh = rh && (run_hi >= eff_dt(dt_hi) + 1);
        nl = rl && (run_lo >= eff_dt(dt_lo) + 1);
        ne = exp_err | (exp_hi & exp_lo & protected_cfg());
        th = edge_tag(exp_hi, nh, eff_dt(dt_hi));
        tl = edge_tag(exp_lo, nl, eff_dt(dt_lo));
        exp_hi = nh;
        exp_lo = nl;
        exp_err = ne;
        @(negedge clk);
        chk(th, "gate_hi", gate_hi, exp_hi);
        chk(tl, "gate_lo", gate_lo, exp_lo);
        chk("R10", "overlap_err", overlap_err, exp_err);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pwm_a = 1'b0;
        pwm_b = 1'b0;
        run_hi = 0;
        run_lo = 0;
        exp_hi = 1'b0;
        exp_lo = 1'b0;
        exp_err = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "gate_hi in reset", gate_hi, 1'b0);
        chk("R1", "gate_lo in reset", gate_lo, 1'b0);
        chk("R1", "err in reset", overlap_err, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic rand_phase(input logic [1:0] m, input logic [1:0] p, input int n);
        logic a, b;
        in_mode  = m;
        path_sel = p;
        dt_hi = DT_W'($urandom_range(0, 15));
        dt_lo = DT_W'($urandom_range(0, 15));
        do_reset();
        // R1: first cycle after release, inputs low
        cycle(1'b0, 1'b0);
        for (int k = 0; k < n; k++) begin
            int hold;
            a = 1'($urandom_range(0, 1));
            b = 1'($urandom_range(0, 1));
            hold = $urandom_range(1, 24);
            for (int j = 0; j < hold; j++) cycle(a, b);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17_C0DE));
        in_mode = 2'd0;
        path_sel = 2'd0;
        dt_hi = 4'd1;
        dt_lo = 4'd1;
        pwm_a = 1'b0;
        pwm_b = 1'b0;
        rst_n = 1'b0;

        // random sweep over every mode and path
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 4; p++)
                rand_phase(2'(m), 2'(p), 40);

        // R5 boundaries: zero and largest delay in buck
        in_mode = 2'd0; path_sel = 2'd0; dt_hi = 4'd0; dt_lo = 4'd15;
        do_reset();
        force_tag = "R5";
        for (int j = 0; j < 20; j++) cycle(1'b0, 1'b0);
        for (int j = 0; j < 20; j++) cycle(1'b1, 1'b0);
        for (int j = 0; j < 20; j++) cycle(1'b0, 1'b0);
        force_tag = "";

        // R7 restart: request shorter than the delay, then a full one
        in_mode = 2'd0; path_sel = 2'd0; dt_hi = 4'd6; dt_lo = 4'd2;
        do_reset();
        force_tag = "R7";
        for (int j = 0; j < 10; j++) cycle(1'b0, 1'b0);
        for (int j = 0; j < 4; j++)  cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        for (int j = 0; j < 5; j++)  cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        for (int j = 0; j < 12; j++) cycle(1'b1, 1'b0);
        force_tag = "";

        // R3 and R6: boost with long delays, pwm_b toggled to show it is ignored
        in_mode = 2'd1; path_sel = 2'd0; dt_hi = 4'd9; dt_lo = 4'd12;
        do_reset();
        for (int j = 0; j < 30; j++) cycle(1'b1, 1'(j % 2));
        for (int j = 0; j < 30; j++) cycle(1'b0, 1'(j % 3 == 0));

        // R10: both gates high in dual, then switch to protected buck
        in_mode = 2'd2; path_sel = 2'd0; dt_hi = 4'd3; dt_lo = 4'd3;
        do_reset();
        force_tag = "R10";
        for (int j = 0; j < 10; j++) cycle(1'b1, 1'b1);
        in_mode = 2'd0;
        for (int j = 0; j < 10; j++) cycle(1'b1, 1'b0);
        chk("R10", "err set after overlap", overlap_err, 1'b1);
        for (int j = 0; j < 10; j++) cycle(1'b0, 1'b0);
        chk("R10", "err still set", overlap_err, 1'b1);
        force_tag = "";
        do_reset();
        chk("R10", "err cleared by reset", overlap_err, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule